// File: doc/BRIEF.md
# Dual-Resolution Successive-Approximation Converter Controller

This block is the digital half of a successive-approximation analog-to-digital converter. An eight-way analog multiplexer, a trial DAC and a comparator sit outside it. A start strobe latches a channel number and a resolution choice. The block then counts machine cycles, which arrive as a one-clock enable. It first gives a sampling interval. It then tests one bit per decision step, from the most significant bit down, and presents each trial code to the DAC. The comparator answer decides whether the bit stays set.

The full-resolution mode produces a 10-bit straight-binary code over a fixed 50 machine cycles. The fast mode produces an 8-bit code over a fixed 24 machine cycles. In both modes, eight result bits go to a high result register. In full mode, the two bits below them go to a low field. A completion flag marks a finished result. An idle option chooses what happens when the processor idles: the converter either keeps working, or it is gated off and any running conversion is abandoned.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, dac_code_o, chan_sel_o, res_hi_o and res_lo_o are all zero.
- R2: An accepted start latches chan_i onto chan_sel_o on its clock edge, and chan_sel_o holds that value for the whole conversion.
- R3: Full mode (mode8_i=0) is a binary search. cmp_i=1 means the selected input is at or above dac_code_o, and the tested bit is then kept. The final 10-bit code R gives res_hi_o=R[9:2] and res_lo_o=R[1:0].
- R4: In full mode, done_o rises on the edge of the 50th machine-cycle enable after the accepted start, and busy_o falls on that same edge.
- R5: In fast mode (mode8_i=1), only dac_code_o[9:2] is searched and dac_code_o[1:0] stays 0. res_hi_o holds the 8-bit result, and res_lo_o is 0.
- R6: In fast mode, done_o rises on the edge of the 24th machine-cycle enable after the accepted start.
- R7: dac_code_o is 0 during sampling, which lasts 10 enables in full mode and 8 in fast mode. Bit 9 alone is presented after that. Later bits are then decided every 4 enables in full mode and every 2 in fast mode.
- R8: A start while busy_o is high has no effect. The channel, the mode, the timing and the result of the running conversion are unchanged.
- R9: done_o stays set after completion until the next accepted start, which clears it on its accepting edge.
- R10: With idle_keep_i=1, asserting idle_i leaves a conversion's timing and result unchanged.
- R11: With idle_i=1 and idle_keep_i=0, the block aborts at the next edge. busy_o, done_o and dac_code_o go to 0, res_hi_o and res_lo_o keep their values, and starts are ignored.
- R12: A clock with mcyc_en_i low does not advance a conversion, and dac_code_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion start strobe |
| chan_i | input | 3 | Channel to convert |
| mode8_i | input | 1 | 1 selects fast 8-bit mode |
| idle_i | input | 1 | Processor is in idle |
| idle_keep_i | input | 1 | 1 keeps the converter running in idle |
| mcyc_en_i | input | 1 | One-clock machine-cycle enable |
| cmp_i | input | 1 | Comparator: input at or above trial code |
| dac_code_o | output | 10 | Trial code for the DAC |
| chan_sel_o | output | 3 | Multiplexer select |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Completion flag |
| res_hi_o | output | 8 | Upper result byte |
| res_lo_o | output | 2 | Lower two result bits (full mode) |

## Verification
The hardest state to reach is a start strobe that arrives partway through a running conversion and asks for another channel and the other mode. The accepting path must refuse it while the counter keeps going. The bench drives such a strobe after twenty machine cycles of a full-mode conversion and then counts enables to the original 50-cycle finish. It also aborts a conversion by gated idle and then sends a start while still gated. The comparator and multiplexer models answer from the outputs the block drives, so any drift in channel or trial code shows up in the result.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int RES_W      = 10;
  localparam int FAST_W     = 8;
  localparam int CYC_FULL   = 50;
  localparam int CYC_FAST   = 24;
  localparam int STEP_FULL_LG = 2;
  localparam int STEP_FAST_LG = 1;
  localparam int CHAN_N     = 8;
endpackage

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int CYC_FULL     = sar_pkg::CYC_FULL,
  parameter int CYC_FAST     = sar_pkg::CYC_FAST,
  parameter int STEP_FULL_LG = sar_pkg::STEP_FULL_LG,
  parameter int STEP_FAST_LG = sar_pkg::STEP_FAST_LG,
  parameter int BITS_FULL    = sar_pkg::RES_W,
  parameter int BITS_FAST    = sar_pkg::FAST_W,
  localparam int CNT_W = $clog2(CYC_FULL + 1),
  localparam int IDX_W = $clog2(BITS_FULL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             gate,
  input  logic             mcyc_en,
  input  logic             mode8,
  output logic             busy,
  output logic             mode_q,
  output logic             load_msb,
  output logic             decide,
  output logic [IDX_W-1:0] idx,
  output logic             finish
);
  localparam int SAMP_FULL = CYC_FULL - (BITS_FULL << STEP_FULL_LG);
  localparam int SAMP_FAST = CYC_FAST - (BITS_FAST << STEP_FAST_LG);
  localparam logic [CNT_W-1:0] TOT_FULL_C  = CNT_W'(CYC_FULL);
  localparam logic [CNT_W-1:0] TOT_FAST_C  = CNT_W'(CYC_FAST);
  localparam logic [CNT_W-1:0] SAMP_FULL_C = CNT_W'(SAMP_FULL);
  localparam logic [CNT_W-1:0] SAMP_FAST_C = CNT_W'(SAMP_FAST);
  localparam logic [CNT_W-1:0] MASK_FULL_C = CNT_W'((1 << STEP_FULL_LG) - 1);
  localparam logic [CNT_W-1:0] MASK_FAST_C = CNT_W'((1 << STEP_FAST_LG) - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] total, samp, mask, rel;
  logic             tick;

  always_comb begin
    total = mode_q ? TOT_FAST_C  : TOT_FULL_C;
    samp  = mode_q ? SAMP_FAST_C : SAMP_FULL_C;
    mask  = mode_q ? MASK_FAST_C : MASK_FULL_C;
    tick  = busy_q && mcyc_en && !gate;
    rel   = cnt_q - samp;
    idx   = mode_q ? IDX_W'(rel >> STEP_FAST_LG) : IDX_W'(rel >> STEP_FULL_LG);
    load_msb = tick && (cnt_q == samp - 1'b1);
    decide   = tick && (cnt_q >= samp) && ((rel & mask) == mask);
    finish   = tick && (cnt_q == total - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else if (gate) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      mode_q <= mode8;
    end else if (tick) begin
      if (finish) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy = busy_q;

  a_r8_count_runs_on: assert property (@(posedge clk) disable iff (rst)
    (busy_q && mcyc_en && !gate && (cnt_q != total - 1'b1)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r12_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !mcyc_en && !gate && !accept) |=> $stable(cnt_q));
  a_r4_length: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !gate && mcyc_en && (cnt_q == total - 1'b1)) |=> !busy_q);
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
  parameter int RES_W  = sar_pkg::RES_W,
  parameter int FAST_W = sar_pkg::FAST_W,
  localparam int IDX_W = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             gate,
  input  logic             mode8,
  input  logic             load_msb,
  input  logic             decide,
  input  logic             finish,
  input  logic [IDX_W-1:0] idx,
  input  logic             cmp,
  output logic [RES_W-1:0] code_q,
  output logic [RES_W-1:0] code_next
);
  localparam logic [IDX_W-1:0] TOP_C  = IDX_W'(RES_W - 1);
  localparam logic [IDX_W-1:0] LSB_FAST_C = IDX_W'(RES_W - FAST_W);
  localparam logic [RES_W-1:0] MSB_ONE = RES_W'(1) << (RES_W - 1);

  logic [IDX_W-1:0] pos, lsb;

  always_comb begin
    pos = TOP_C - idx;
    lsb = mode8 ? LSB_FAST_C : '0;
    code_next = code_q;
    if (!cmp) code_next[pos] = 1'b0;
    if (pos > lsb) code_next[pos - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || gate || accept || finish) code_q <= '0;
    else if (load_msb) code_q <= MSB_ONE;
    else if (decide) code_q <= code_next;
  end

  a_r5_fast_low_zero: assert property (@(posedge clk) disable iff (rst)
    mode8 |-> (code_q[RES_W-FAST_W-1:0] == '0));
  a_r7_msb_first: assert property (@(posedge clk) disable iff (rst)
    (load_msb && !accept) |=> (code_q == MSB_ONE));
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int RES_W  = sar_pkg::RES_W,
  parameter int FAST_W = sar_pkg::FAST_W,
  localparam int LO_W = RES_W - FAST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              gate,
  input  logic              finish,
  input  logic              mode8,
  input  logic [RES_W-1:0]  code_next,
  output logic [FAST_W-1:0] hi_q,
  output logic [LO_W-1:0]   lo_q,
  output logic              done_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      lo_q   <= '0;
      done_q <= 1'b0;
    end else if (gate || accept) begin
      done_q <= 1'b0;
    end else if (finish) begin
      hi_q   <= code_next[RES_W-1:LO_W];
      lo_q   <= mode8 ? '0 : code_next[LO_W-1:0];
      done_q <= 1'b1;
    end
  end

  a_r9_start_clears_done: assert property (@(posedge clk) disable iff (rst)
    accept |=> !done_q);
  a_r11_gate_clears_done: assert property (@(posedge clk) disable iff (rst)
    gate |=> !done_q);
  a_r11_result_kept: assert property (@(posedge clk) disable iff (rst)
    gate |=> ($stable(hi_q) && $stable(lo_q)));
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done_q && !accept && !gate) |=> done_q);
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int RES_W  = sar_pkg::RES_W,
  parameter int FAST_W = sar_pkg::FAST_W,
  parameter int CHAN_N = sar_pkg::CHAN_N,
  localparam int CH_W = $clog2(CHAN_N),
  localparam int LO_W = RES_W - FAST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              mode8_i,
  input  logic              idle_i,
  input  logic              idle_keep_i,
  input  logic              mcyc_en_i,
  input  logic              cmp_i,
  output logic [RES_W-1:0]  dac_code_o,
  output logic [CH_W-1:0]   chan_sel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [FAST_W-1:0] res_hi_o,
  output logic [LO_W-1:0]   res_lo_o
);
  localparam int IDX_W = $clog2(RES_W);

  logic             gate, accept, busy, mode_q, load_msb, decide, finish;
  logic [IDX_W-1:0] idx;
  logic [RES_W-1:0] code_next;
  logic [CH_W-1:0]  chan_q;

  assign gate   = idle_i && !idle_keep_i;
  assign accept = start_i && !busy && !gate;

  always_ff @(posedge clk) begin
    if (rst) chan_q <= '0;
    else if (accept) chan_q <= chan_i;
  end

  sar_seq #(
    .BITS_FULL(RES_W), .BITS_FAST(FAST_W)
  ) u_seq (
    .clk(clk), .rst(rst), .accept(accept), .gate(gate), .mcyc_en(mcyc_en_i),
    .mode8(mode8_i), .busy(busy), .mode_q(mode_q), .load_msb(load_msb),
    .decide(decide), .idx(idx), .finish(finish)
  );

  sar_trial #(.RES_W(RES_W), .FAST_W(FAST_W)) u_trial (
    .clk(clk), .rst(rst), .accept(accept), .gate(gate), .mode8(mode_q),
    .load_msb(load_msb), .decide(decide), .finish(finish), .idx(idx),
    .cmp(cmp_i), .code_q(dac_code_o), .code_next(code_next)
  );

  sar_result #(.RES_W(RES_W), .FAST_W(FAST_W)) u_res (
    .clk(clk), .rst(rst), .accept(accept), .gate(gate), .finish(finish),
    .mode8(mode_q), .code_next(code_next), .hi_q(res_hi_o), .lo_q(res_lo_o),
    .done_q(done_o)
  );

  assign chan_sel_o = chan_q;
  assign busy_o     = busy;

  a_r2_chan_held: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(chan_sel_o));
  a_r11_gated_idle: assert property (@(posedge clk) disable iff (rst)
    gate |=> (!busy_o && (dac_code_o == '0)));
  a_r8_no_double_start: assert property (@(posedge clk) disable iff (rst)
    (busy && start_i && !gate && !finish) |=> busy_o);
endmodule

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, mode8_i = 0, idle_i = 0, idle_keep_i = 0, mcyc_en_i = 0;
  logic [2:0] chan_i = '0;
  logic cmp_i;
  logic [9:0] dac_code_o;
  logic [2:0] chan_sel_o;
  logic busy_o, done_o;
  logic [7:0] res_hi_o;
  logic [1:0] res_lo_o;
  logic [9:0] ain [8];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  assign cmp_i = (ain[chan_sel_o] >= dac_code_o);

  sar_adc_ctrl u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i), .mode8_i(mode8_i),
    .idle_i(idle_i), .idle_keep_i(idle_keep_i), .mcyc_en_i(mcyc_en_i), .cmp_i(cmp_i),
    .dac_code_o(dac_code_o), .chan_sel_o(chan_sel_o), .busy_o(busy_o), .done_o(done_o),
    .res_hi_o(res_hi_o), .res_lo_o(res_lo_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic mcyc(input int gap);
    @(negedge clk) mcyc_en_i = 1'b1;
    @(negedge clk) mcyc_en_i = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic pulse_start(input int ch, input bit m8);
    @(negedge clk);
    start_i = 1'b1; chan_i = 3'(ch); mode8_i = m8;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic check_result(input int ch, input bit m8, input string req);
    chk(res_hi_o == ain[ch][9:2], req, res_hi_o, ain[ch][9:2]);
    chk(res_lo_o == (m8 ? 2'b00 : ain[ch][1:0]), req, res_lo_o, m8 ? 0 : ain[ch][1:0]);
  endtask

  task automatic conv(input int ch, input bit m8, input int gap);
    int total = m8 ? 24 : 50;
    int samp  = m8 ? 8 : 10;
    bit lowbad = 0;
    pulse_start(ch, m8);
    chk(busy_o == 1'b1, "R9", busy_o, 1);
    chk(done_o == 1'b0, "R9", done_o, 0);
    chk(chan_sel_o == 3'(ch), "R2", chan_sel_o, ch);
    for (int i = 1; i <= total; i++) begin
      mcyc(gap);
      if (i == samp - 1) chk(dac_code_o == 10'h000, "R7", dac_code_o, 0);
      if (i == samp) chk(dac_code_o == 10'h200, "R7", dac_code_o, 10'h200);
      if (i == total - 1) chk(done_o == 1'b0, m8 ? "R6" : "R4", done_o, 0);
      if (m8 && dac_code_o[1:0] != 2'b00) lowbad = 1;
      if (i < total && chan_sel_o != 3'(ch)) lowbad = 1;
    end
    chk(!lowbad, m8 ? "R5" : "R2", lowbad, 0);
    chk(done_o == 1'b1 && busy_o == 1'b0, m8 ? "R6" : "R4", {done_o, busy_o}, 2);
    check_result(ch, m8, m8 ? "R5" : "R3");
  endtask

  task automatic t_reset;
    chk(busy_o == 0 && done_o == 0, "R1", {busy_o, done_o}, 0);
    chk(dac_code_o == 0 && chan_sel_o == 0, "R1", dac_code_o, 0);
    chk(res_hi_o == 0 && res_lo_o == 0, "R1", res_hi_o, 0);
  endtask

  task automatic t_full;
    conv(3, 0, 0);
    conv(7, 0, 2);
    conv(0, 0, 1);
    conv(6, 0, 0);
  endtask

  task automatic t_fast;
    conv(5, 1, 0);
    conv(7, 1, 1);
  endtask

  task automatic t_busy_start;
    pulse_start(1, 0);
    repeat (20) mcyc(0);
    pulse_start(6, 1);
    chk(chan_sel_o == 3'd1 && busy_o, "R8", chan_sel_o, 1);
    repeat (29) mcyc(0);
    chk(done_o == 0, "R8", done_o, 0);
    mcyc(0);
    chk(done_o == 1, "R8", done_o, 1);
    check_result(1, 0, "R8");
  endtask

  task automatic t_done_sticky;
    repeat (10) @(negedge clk);
    chk(done_o == 1, "R9", done_o, 1);
    pulse_start(2, 1);
    chk(done_o == 0, "R9", done_o, 0);
    repeat (24) mcyc(0);
    chk(done_o == 1, "R9", done_o, 1);
  endtask

  task automatic t_stall;
    logic [9:0] held;
    pulse_start(3, 0);
    repeat (12) mcyc(0);
    held = dac_code_o;
    repeat (20) @(negedge clk);
    chk(dac_code_o == held && busy_o, "R12", dac_code_o, held);
    repeat (37) mcyc(0);
    chk(done_o == 0, "R12", done_o, 0);
    mcyc(0);
    chk(done_o == 1, "R12", done_o, 1);
    check_result(3, 0, "R12");
  endtask

  task automatic t_idle_keep;
    idle_keep_i = 1'b1;
    pulse_start(2, 0);
    repeat (15) mcyc(0);
    idle_i = 1'b1;
    repeat (34) mcyc(0);
    chk(done_o == 0, "R10", done_o, 0);
    mcyc(0);
    chk(done_o == 1, "R10", done_o, 1);
    check_result(2, 0, "R10");
    idle_i = 1'b0;
  endtask

  task automatic t_idle_gate;
    logic [7:0] hi0;
    logic [1:0] lo0;
    hi0 = res_hi_o; lo0 = res_lo_o;
    idle_keep_i = 1'b0;
    pulse_start(4, 0);
    repeat (20) mcyc(0);
    @(negedge clk) idle_i = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && dac_code_o == 0, "R11", {busy_o, done_o, dac_code_o}, 0);
    chk(res_hi_o == hi0 && res_lo_o == lo0, "R11", res_hi_o, hi0);
    pulse_start(5, 1);
    chk(busy_o == 0, "R11", busy_o, 0);
    repeat (60) mcyc(0);
    chk(done_o == 0 && res_hi_o == hi0, "R11", done_o, 0);
    @(negedge clk) idle_i = 1'b0;
    conv(4, 0, 0);
  endtask

  initial begin
    ain[0] = 10'h000; ain[1] = 10'h155; ain[2] = 10'h0F3; ain[3] = 10'h2A7;
    ain[4] = 10'h1FF; ain[5] = 10'h2A7; ain[6] = 10'h200; ain[7] = 10'h3FF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full();
    t_fast();
    t_busy_start();
    t_done_sticky();
    t_stall();
    t_idle_keep();
    t_idle_gate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule